// File: doc/BRIEF.md
# Bit-Field Insert, Extract and Partition Permute Unit

This unit handles three bit-manipulation operations on a 64-bit word. Each request arrives with a one-cycle valid strobe and yields a registered result one cycle later. An insert takes a field held at the bottom of the source and writes it into the destination word at a chosen bit position. All destination bits outside the field are kept. An extract reads a field at a chosen bit position and returns it at the bottom of the result. The bits above the field are either cleared or filled with copies of the field's top bit.

Positions wrap around the word. A field that runs past bit 63 continues at bit 0, so a field can span the top and bottom ends of the register. The third operation, permute, treats the word as four 16-bit quarters. Each quarter of the result is filled from a source quarter picked by a 2-bit code in the selector. Instruction decode and condition flags are handled elsewhere in the pipeline.

Top module: `bitfield_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `result` are both zero after that edge.
- R2: With opcode 0 (insert), let M be a run of `length` ones starting at bit `offset`. The result is `dst_i` with the bits under M replaced by the low `length` bits of `src_i`, moved up to `offset`.
- R3: With opcode 1 (extract) and `sext` = 0, bits [length-1:0] of the result hold `src_i` bits `offset` .. `offset+length-1`, and every bit above them is zero.
- R4: With opcode 1 and `sext` = 1, every result bit above the field equals the field's top bit, which is result bit `length-1`.
- R5: A `length` code of 0 selects a 64-bit field. An insert then returns `src_i` rotated left by `offset`. An extract returns `src_i` rotated right by `offset`.
- R6: Field bit positions are taken modulo 64. A field that passes bit 63 continues at bit 0, for both insert and extract.
- R7: With opcode 2 (permute), result bits [16k+15:16k] equal `src_i` quarter number `sel[2k+1:2k]`, for k = 0..3. Quarter 0 is bits [15:0].
- R8: `out_valid` at a clock edge equals `in_valid` at the edge before, so each result appears one cycle after its request.
- R9: When `in_valid` is low at an edge, `result` keeps its previous value.
- R10: With opcode 3 (unused), an accepted request produces a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| opcode | input | 2 | 0 insert, 1 extract, 2 permute, 3 unused |
| src_i | input | 64 | Source word |
| dst_i | input | 64 | Destination word (insert only) |
| offset | input | 6 | Field bit position |
| length | input | 6 | Field width, 0 meaning 64 |
| sel | input | 8 | Four 2-bit quarter selectors for permute |
| sext | input | 1 | Extract fills upper bits from the field's top bit |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Registered result |

## Verification
Two of the unit's functions can occur in the same cycle. One is presenting the result of one request. The other is capturing the next request on the same edge, whether that request is a different operation or an idle cycle that must leave the result unchanged. The bench issues back-to-back requests that switch between insert, extract and permute. It mixes in idle gaps and also sends requests whose fields wrap past bit 63 or use the full-width code. A behavioural model, built with bit loops and modulo positions, predicts `out_valid` and `result` for every cycle. The outputs are compared against it on each falling edge, so any result that leaks into the wrong cycle or is lost across a back-to-back pair shows up.

// File: rtl/bfu_pkg.sv
// Shared types for the bit-field unit.
package bfu_pkg;
    typedef enum logic [1:0] {
        OP_INSERT  = 2'd0,
        OP_EXTRACT = 2'd1,
        OP_PERMUTE = 2'd2,
        OP_NONE    = 2'd3
    } bfu_op_e;
endpackage

// File: rtl/bfu_mask_gen.sv
// Builds a right-aligned run of ones of the requested length.
// Assumes W is a power of two; a length code of 0 means W ones.
module bfu_mask_gen #(
    parameter int W     = 64,
    parameter int POS_W = $clog2(W)
) (
    input  logic [POS_W-1:0] len,
    output logic [W-1:0]     low_mask
);
    logic [POS_W:0] drop;

    // purpose: shift an all-ones word down so that len ones remain
    always_comb begin
        drop = (POS_W+1)'(W) - {1'b0, len};
        if (len == '0) low_mask = '1;
        else           low_mask = {W{1'b1}} >> drop;
    end
endmodule

// File: rtl/bfu_rotator.sv
// Barrel rotator; LEFT selects the direction at elaboration.
// Assumes amt is below W.
module bfu_rotator #(
    parameter int W     = 64,
    parameter int POS_W = $clog2(W),
    parameter bit LEFT  = 1'b1
) (
    input  logic [W-1:0]     a,
    input  logic [POS_W-1:0] amt,
    output logic [W-1:0]     y
);
    logic [2*W-1:0] doubled;
    logic [2*W-1:0] shifted;

    assign doubled = {a, a};

    generate
        if (LEFT) begin : g_left
            // purpose: rotate left by taking the upper half of a doubled shift
            always_comb begin
                shifted = doubled << amt;
                y       = shifted[2*W-1:W];
            end
        end else begin : g_right
            // purpose: rotate right by taking the lower half of a doubled shift
            always_comb begin
                shifted = doubled >> amt;
                y       = shifted[W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/bfu_permute.sv
// Partition permute: output partition k copies source partition sel[k].
// Assumes PARTS is a power of two dividing W.
module bfu_permute #(
    parameter int W     = 64,
    parameter int PARTS = 4,
    parameter int IDX_W = $clog2(PARTS),
    parameter int SEL_W = PARTS * IDX_W
) (
    input  logic [W-1:0]     src,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     y
);
    localparam int PW = W / PARTS;

    logic [PW-1:0] part [PARTS];

    generate
        for (genvar p = 0; p < PARTS; p++) begin : g_split
            assign part[p] = src[p*PW +: PW];
        end
        for (genvar k = 0; k < PARTS; k++) begin : g_route
            // purpose: pick the source partition named by this lane's code
            assign y[k*PW +: PW] = part[sel[k*IDX_W +: IDX_W]];
        end
    endgenerate
endmodule

// File: rtl/bitfield_unit.sv
// Bit-field insert / extract / partition permute with a registered result.
// Field positions wrap modulo DATA_W; length code 0 means full width.
// The result register loads only on in_valid; out_valid trails in_valid by one cycle.
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PARTS  = 4,
    parameter int POS_W  = $clog2(DATA_W),
    parameter int SEL_W  = PARTS * $clog2(PARTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        opcode,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [POS_W-1:0]  offset,
    input  logic [POS_W-1:0]  length,
    input  logic [SEL_W-1:0]  sel,
    input  logic              sext,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] place_mask;
    logic [DATA_W-1:0] src_up;
    logic [DATA_W-1:0] src_down;
    logic [DATA_W-1:0] perm_y;
    logic [DATA_W-1:0] ins_y;
    logic [DATA_W-1:0] ext_y;
    logic [DATA_W-1:0] next_y;
    logic [POS_W-1:0]  top_idx;
    logic              top_bit;

    bfu_mask_gen #(.W(DATA_W), .POS_W(POS_W)) u_mask (
        .len      (length),
        .low_mask (low_mask)
    );

    bfu_rotator #(.W(DATA_W), .POS_W(POS_W), .LEFT(1'b1)) u_rot_mask (
        .a   (low_mask),
        .amt (offset),
        .y   (place_mask)
    );

    bfu_rotator #(.W(DATA_W), .POS_W(POS_W), .LEFT(1'b1)) u_rot_up (
        .a   (src_i),
        .amt (offset),
        .y   (src_up)
    );

    bfu_rotator #(.W(DATA_W), .POS_W(POS_W), .LEFT(1'b0)) u_rot_down (
        .a   (src_i),
        .amt (offset),
        .y   (src_down)
    );

    bfu_permute #(.W(DATA_W), .PARTS(PARTS), .SEL_W(SEL_W)) u_perm (
        .src (src_i),
        .sel (sel),
        .y   (perm_y)
    );

    // purpose: merge the placed source field into the destination
    always_comb begin
        ins_y = (dst_i & ~place_mask) | (src_up & place_mask);
    end

    // purpose: isolate the extracted field and optionally sign-fill above it
    always_comb begin
        top_idx = length - POS_W'(1);
        top_bit = src_down[top_idx];
        ext_y   = src_down & low_mask;
        if (sext && top_bit) ext_y = ext_y | ~low_mask;
    end

    // purpose: choose the operation result by opcode
    always_comb begin
        unique case (bfu_op_e'(opcode))
            OP_INSERT:  next_y = ins_y;
            OP_EXTRACT: next_y = ext_y;
            OP_PERMUTE: next_y = perm_y;
            default:    next_y = '0;
        endcase
    end

    // purpose: register the result and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_y;
        end
    end
endmodule

// File: rtl/bfu_checker.sv
// Temporal properties of bitfield_unit, attached by bind below.
module bfu_checker #(
    parameter int DATA_W = 64,
    parameter int POS_W  = 6,
    parameter int SEL_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        opcode,
    input logic [DATA_W-1:0] src_i,
    input logic [POS_W-1:0]  offset,
    input logic [POS_W-1:0]  length,
    input logic [SEL_W-1:0]  sel,
    input logic              sext,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    localparam logic [SEL_W-1:0] SEL_IDENT = SEL_W'(8'b11_10_01_00);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 2'd3) |=> result == '0);

    p_extract_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 2'd1 && !sext && length != '0)
        |=> (result >> $past(length)) == '0);

    p_full_insert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 2'd0 && length == '0 && offset == '0)
        |=> result == $past(src_i));

    p_identity_permute_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 2'd2 && sel == SEL_IDENT)
        |=> result == $past(src_i));
endmodule

bind bitfield_unit bfu_checker #(
    .DATA_W (DATA_W),
    .POS_W  (POS_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .src_i     (src_i),
    .offset    (offset),
    .length    (length),
    .sel       (sel),
    .sext      (sext),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/bitfield_unit_tb.sv
module bitfield_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  opcode = '0;
    logic [63:0] src_i = '0;
    logic [63:0] dst_i = '0;
    logic [5:0]  offset = '0;
    logic [5:0]  length = '0;
    logic [7:0]  sel = '0;
    logic        sext = 1'b0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    bit edge_seen = 1'b0;
    bit done = 1'b0;

    logic [63:0] exp_res = '0;
    logic        exp_val = 1'b0;
    string       exp_tag = "R1";

    always #5 clk = ~clk;

    bitfield_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .src_i(src_i), .dst_i(dst_i), .offset(offset), .length(length),
        .sel(sel), .sext(sext), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] s,
                                          input logic [63:0] d, input int off, input int ln,
                                          input logic [7:0] sl, input logic sx);
        logic [63:0] r;
        int n;
        n = (ln == 0) ? 64 : ln;
        r = '0;
        case (op)
            2'd0: begin
                r = d;
                for (int j = 0; j < n; j++) r[(off + j) % 64] = s[j];
            end
            2'd1: begin
                for (int j = 0; j < n; j++) r[j] = s[(off + j) % 64];
                if (sx && r[n-1]) for (int j = n; j < 64; j++) r[j] = 1'b1;
            end
            2'd2: begin
                for (int k = 0; k < 4; k++) r[k*16 +: 16] = s[int'(sl[2*k +: 2])*16 +: 16];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] op, input int off, input int ln,
                                     input logic sx);
        if (op == 2'd3) return "R10";
        if (op == 2'd2) return "R7";
        if (ln == 0) return "R5";
        if (off + ln > 64) return "R6";
        if (op == 2'd0) return "R2";
        return sx ? "R4" : "R3";
    endfunction

    // Behavioural reference, one step per rising edge
    always @(posedge clk) begin
        edge_seen <= 1'b1;
        if (!rst_n) begin
            exp_val <= 1'b0;
            exp_res <= '0;
            exp_tag <= "R1";
        end else begin
            exp_val <= in_valid;
            if (in_valid) begin
                exp_res <= model(opcode, src_i, dst_i, offset, length, sel, sext);
                exp_tag <= tag_of(opcode, offset, length, sext);
            end else begin
                exp_tag <= "R9";
            end
        end
    end

    // Comparison on every falling edge
    always @(negedge clk) begin
        if (edge_seen && !done) begin
            checks++;
            if (out_valid !== exp_val) begin
                fails++;
                $display("FAIL R8 out_valid actual=%b expected=%b", out_valid, exp_val);
            end
            checks++;
            if (result !== exp_res) begin
                fails++;
                $display("FAIL %s result actual=%h expected=%h", exp_tag, result, exp_res);
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [63:0] s, input logic [63:0] d,
                         input logic [5:0] off, input logic [5:0] ln, input logic [7:0] sl,
                         input logic sx);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; src_i = s; dst_i = d;
        offset = off; length = ln; sel = sl; sext = sx;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_i = {$urandom, $urandom};
            opcode = 2'($urandom);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] a;
        logic [63:0] b;
        a = 64'hF0E1_D2C3_B4A5_9687;
        b = 64'h0123_4567_89AB_CDEF;
        repeat (3) @(negedge clk);           // R1 reset state compared each cycle
        @(negedge clk); rst_n = 1'b1;
        // R2 plain insert, offset 0 and offset 63 corners
        issue(2'd0, a, b, 6'd8, 6'd12, 8'h00, 1'b0);
        issue(2'd0, a, b, 6'd0, 6'd7, 8'h00, 1'b0);
        issue(2'd0, a, b, 6'd63, 6'd1, 8'h00, 1'b0);
        // R6 wrap across bit 63
        issue(2'd0, a, b, 6'd60, 6'd10, 8'h00, 1'b0);
        issue(2'd1, a, b, 6'd63, 6'd9, 8'h00, 1'b0);
        // R5 full width
        issue(2'd0, a, b, 6'd0, 6'd0, 8'h00, 1'b0);
        issue(2'd0, a, b, 6'd63, 6'd0, 8'h00, 1'b0);
        issue(2'd1, a, b, 6'd17, 6'd0, 8'h00, 1'b1);
        // R3 / R4 extract zero and sign fill
        issue(2'd1, a, b, 6'd4, 6'd8, 8'h00, 1'b0);
        issue(2'd1, a, b, 6'd4, 6'd8, 8'h00, 1'b1);
        issue(2'd1, a, b, 6'd0, 6'd1, 8'h00, 1'b1);
        // R7 permute patterns
        issue(2'd2, a, b, 6'd0, 6'd0, 8'b11_10_01_00, 1'b0);
        issue(2'd2, a, b, 6'd0, 6'd0, 8'b00_01_10_11, 1'b0);
        issue(2'd2, a, b, 6'd0, 6'd0, 8'b10_10_10_10, 1'b0);
        // R10 unused opcode, then R9 hold over idle cycles
        issue(2'd3, a, b, 6'd5, 6'd5, 8'hFF, 1'b1);
        issue(2'd2, a, b, 6'd0, 6'd0, 8'b01_11_00_10, 1'b0);
        idle(4);
        // R8 back-to-back mix with random gaps
        for (int i = 0; i < 400; i++) begin
            issue(2'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                  6'($urandom), 6'($urandom), 8'($urandom), 1'($urandom));
            if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
        end
        // R1 reset mid-stream
        issue(2'd0, a, b, 6'd3, 6'd3, 8'h00, 1'b0);
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
        idle(3);
        finish_run();
    end
endmodule